// File: doc/BRIEF.md
# EPROM Control Logic Model

This block models the control side of a byte-wide UV-erasable read-only memory. The storage is an internal array. Around it, the block decodes the operating mode from three active-low strobes (chip select, output gate, program strobe), a flag that stands for the programming supply being raised, and a flag that stands for the high voltage on address line 9. From that mode it decides whether the data port drives a byte and, when it does, which byte that is.

The data port is split into an input bus, an output bus and an output-enable, so that a pad ring or a wrapper can tri-state it. A program operation only clears bits. The only way to set bits back to 1 is a separate synchronous erase input, which returns the whole array to all ones. A signature mode returns a fixed manufacturer byte and a fixed device byte, chosen by address bit 0.

The mode is sampled on each rising clock edge. The output-enable and output data are registered, so any mode change appears at the port one clock edge later. The storage depth is 2**ADDR_W bytes. The full-size part uses ADDR_W = 13, which gives 8192 bytes. The default build uses a smaller array so that elaboration stays light.

Top module: `eprom_ctl`

## Requirements
- R1: While rst_n is low, and at the first edge after it, dout_en is 0. After reset every array byte reads back as 0xFF.
- R2: If ce_n is high at an edge, dout_en is 0 after that edge, whatever oe_n, pgm_n and vpp_hi are.
- R3: If ce_n is low and either oe_n is high or pgm_n is low at an edge, dout_en is 0 after that edge.
- R4: If ce_n and oe_n are low, pgm_n is high, and the cycle is not a signature cycle (R9), then after the edge dout_en is 1 and dout holds the byte stored at addr.
- R5: If vpp_hi is 1 and ce_n and pgm_n are both low at an edge, the byte at addr becomes its old value ANDed with din.
- R6: A 1 bit in din never turns a stored 0 back into 1.
- R7: If vpp_hi is 1 and either ce_n or pgm_n is high, no byte changes. The same holds whenever vpp_hi is 0.
- R8: If vpp_hi is 1, ce_n and oe_n are low and pgm_n is high, the stored byte at addr is driven after the edge. This verify read also applies when a9_hv is set.
- R9: A signature cycle has vpp_hi at 0, a9_hv at 1, the read strobes of R4, and every address bit other than bit 0 and bit 9 equal to 0. It drives 0x89 when addr[0] is 0 and 0x08 when addr[0] is 1.
- R10: If a9_hv is 1 but any address bit other than bit 0 or bit 9 is 1, the cycle is an ordinary read of the stored byte.
- R11: If erase is 1 at an edge, every byte becomes 0xFF. Erase wins over a program on the same edge.
- R12: dout_en and dout change only at a rising edge, and they reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also erases the array |
| erase | input | 1 | Synchronous whole-array erase to 0xFF |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage present on address line 9 |
| din | input | 8 | Data from the bus, used when programming |
| dout | output | 8 | Data toward the bus |
| dout_en | output | 1 | Drive enable for dout |

## Verification
Random cycles mix all strobe combinations. Addresses are drawn both from a small pool, which includes the two signature addresses and their copies with bit 9 set, and from the full range. This makes programs, verifies and reads hit the same bytes repeatedly. Repeated programs of one byte with different patterns separate an AND-merge from an overwrite. Signature addresses with an extra bit set separate correct signature decoding from a loose decode. Rare erase pulses, one of them coinciding with a program, separate a full-array erase from a partial one and show which operation has priority. Sampling the port between the input change and the next edge separates registered outputs from combinational ones.

// File: rtl/eprom_ctl.sv
`timescale 1ns/1ps
module eprom_ctl #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int HV_LINE = 9,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h89,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SIG_MASK =
    ~(ADDR_W'(1) | (ADDR_W'(1) << HV_LINE));

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_byte;

  wire rd_strobe = !ce_n && !oe_n && pgm_n;
  wire prog      = vpp_hi && !ce_n && !pgm_n;
  wire sig_hit   = !vpp_hi && a9_hv && ((addr & SIG_MASK) == '0);

  always_comb begin
    rd_byte = mem[addr];
    if (sig_hit) rd_byte = addr[0] ? DEV_CODE : MFR_CODE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= rd_strobe;
      dout    <= rd_strobe ? rd_byte : '0;
    end
  end
endmodule

module eprom_ctl_chk #(
  parameter int ADDR_W  = 11,
  parameter int HV_LINE = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [7:0]        dout,
  input logic              dout_en
);
  localparam logic [ADDR_W-1:0] SIG_MASK =
    ~(ADDR_W'(1) | (ADDR_W'(1) << HV_LINE));

  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_en);
  a_r3_gate_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dout_en);
  a_r3_strobe_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |=> !dout_en);
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && pgm_n) |=> dout_en);
  a_r9_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && pgm_n && !vpp_hi && a9_hv && ((addr & SIG_MASK) == '0) && !addr[0])
      |=> (dout == 8'h89));
  a_r9_dev_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && pgm_n && !vpp_hi && a9_hv && ((addr & SIG_MASK) == '0) && addr[0])
      |=> (dout == 8'h08));
endmodule

bind eprom_ctl eprom_ctl_chk #(.ADDR_W(ADDR_W), .HV_LINE(HV_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv), .dout(dout), .dout_en(dout_en)
);

// File: tb/sim_eprom_ctl.sv
`timescale 1ns/1ps
module sim_eprom_ctl;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] SMASK = ~(AW'(1) | (AW'(1) << 9));

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, erase = 1'b0, ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic vpp_hi = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en;

  eprom_ctl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .erase(erase), .addr(addr), .ce_n(ce_n),
    .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  logic [7:0] ref_mem [DEPTH];
  int n_chk = 0, n_bad = 0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic c, input logic o, input logic p, input logic v,
                        input logic h, input logic [AW-1:0] a, input logic [7:0] d,
                        input logic e);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; a9_hv = h; addr = a; din = d; erase = e;
  endtask

  function automatic string mode_tag();
    if (ce_n) return "R2";
    if (oe_n || !pgm_n) return "R3";
    if (vpp_hi) return "R8";
    if (a9_hv && ((addr & SMASK) == '0)) return "R9";
    if (a9_hv) return "R10";
    return "R4";
  endfunction

  task automatic cyc(input string tag);
    logic exp_en;
    logic [7:0] exp_d;
    exp_en = rst_n && !ce_n && !oe_n && pgm_n;
    exp_d = ref_mem[addr];
    if (!vpp_hi && a9_hv && ((addr & SMASK) == '0)) exp_d = addr[0] ? 8'h08 : 8'h89;
    @(posedge clk); #1;
    check({tag, " en"}, {7'd0, dout_en}, {7'd0, exp_en});
    if (exp_en) check({tag, " data"}, dout, exp_d);
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    end else if (vpp_hi && !ce_n && !pgm_n) begin
      ref_mem[addr] = ref_mem[addr] & din;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00, 1'b0);
    cyc(tag);
  endtask

  task automatic prg(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    set_in(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, d, 1'b0);
    cyc(tag);
  endtask

  initial begin
    #800000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd3, 8'h00, 1'b0);
    cyc("R1");
    cyc("R1");
    @(negedge clk); rst_n = 1'b1;
    rd(11'd3, "R1");
    rd(11'd2047, "R1");

    set_in(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd3, 8'h00, 1'b0);
    cyc("R3");
    set_in(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd3, 8'h00, 1'b0);
    cyc("R2");
    set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd3, 8'h00, 1'b0);
    #1 check("R12 pre-edge en", {7'd0, dout_en}, 8'd0);
    cyc("R12");

    prg(11'd5, 8'hA5, "R5");
    set_in(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'd5, 8'h00, 1'b0);
    cyc("R8");
    prg(11'd5, 8'h5A, "R6");
    rd(11'd5, "R6");

    set_in(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'd6, 8'h00, 1'b0);
    cyc("R7");
    set_in(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'd6, 8'h00, 1'b0);
    cyc("R7");
    set_in(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd6, 8'h00, 1'b0);
    cyc("R7");
    rd(11'd6, "R7");

    set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 8'h00, 1'b0);
    cyc("R9");
    set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 11'h201, 8'h00, 1'b0);
    cyc("R9");
    prg(11'd4, 8'h3C, "R5");
    set_in(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 11'd4, 8'h00, 1'b0);
    cyc("R10");
    set_in(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'd4, 8'h00, 1'b0);
    cyc("R8");

    set_in(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 11'd7, 8'h00, 1'b1);
    cyc("R11");
    rd(11'd7, "R11");
    rd(11'd5, "R11");

    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] a;
      case ($urandom % 4)
        0: a = AW'($urandom % 8);
        1: a = ($urandom % 2) ? 11'h201 : 11'h200;
        default: a = AW'($urandom);
      endcase
      set_in(($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 3) != 0,
             ($urandom % 2) == 1, ($urandom % 4) == 0, a, 8'($urandom),
             ($urandom % 400) == 0);
      cyc(erase ? "R11" : mode_tag());
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule